// File: doc/BRIEF.md
# Multi-Core Global Timer with Banked Comparators

The block keeps a single 64-bit up-counter that all processor cores share. The counter advances once every (prescale + 1) clock cycles while the shared run bit is set. Each core owns a bank that holds a 64-bit comparator, an increment value, three enable bits and a sticky match flag. Each bank drives its own interrupt line. A compare match fires once the counter reaches or passes the comparator. A bank with stepping enabled and a nonzero increment then moves its comparator forward by whole increments until it lies beyond the count.

Software reaches the registers through a 32-bit register bus. The bus has a write strobe, a read strobe, a window number, a byte offset, write data and the ID of the requesting core. Window 1 to N selects the bank of core 0 to N-1. Window 0 is an alias that selects the bank of whichever core issues the access. The shared counter and the shared control bits can be reached from every window.

Top module: `mc_global_timer`

## Requirements
- R1: After reset the counter, the shared control, and every bank's enables, match flag, comparator and increment are zero. All interrupt lines are low and the read data is zero.
- R2: While the run bit (control bit 0) is set, the counter rises by exactly one every (P + 1) cycles, where P is control bits [15:8]. The prescale phase restarts from zero whenever the run bit is clear, and the counter holds while the run bit is clear.
- R3: The counter halves are at offset 0x00 (bits 31:0) and offset 0x04 (bits 63:32). A write to either half loads it only while the run bit is clear. While the run bit is set, such a write has no effect.
- R4: The control register is at offset 0x08. Bit 0 (run) and bits [15:8] (prescale) are shared by all cores. Bit 1 (compare enable), bit 2 (interrupt enable) and bit 3 (step enable) are held per bank. A read returns the shared bits together with the selected bank's bits, and every other bit reads as zero.
- R5: A compare match occurs in a cycle when the run bit and the bank's compare enable are both set and the counter value after that cycle's increment is greater than or equal to the comparator. The match sets the bank's flag, and the flag stays set.
- R6: On a match with step enable set and a nonzero increment, the comparator becomes the smallest value of the form comparator + k × increment, with k ≥ 1, that is strictly greater than the count. If a comparator write arrives in the same cycle, the written value wins.
- R7: The match flag is bit 0 at offset 0x0C. Writing 1 to that bit clears the flag. A match in the same cycle takes precedence over the clear.
- R8: Each interrupt line equals its bank's match flag ANDed with that bank's interrupt enable.
- R9: Window 0 routes an access to the bank given by the core ID. Window k (1 ≤ k ≤ N) routes it to bank k-1. A window above N reads zero and its writes are ignored.
- R10: Offset 0x1C and any offset that is not a multiple of 4 read as zero, and writes to them are ignored.
- R11: Read data is registered. The value appears in the cycle after the read strobe and holds until the next read.
- R12: The comparator halves are at offset 0x10 (bits 31:0) and offset 0x14 (bits 63:32), and the increment is at offset 0x18. All three are per bank and can be read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWin | input | WIN_W | Window: 0 alias, k bank k-1 |
| regOff | input | 5 | Byte offset within the window |
| regCore | input | CORE_W | ID of the requesting core |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| irqOut | output | NUM_CORES | Per-core interrupt lines |

## Verification
The stepping check assumes that the counter and the comparators stay far below the 64-bit wrap point, so that comparator plus increment never overflows. The stimulus loads only small counter values and places comparators a short distance above the current count. The assertions also assume that the bus inputs are defined whenever reset is released. The bench drives every input at the falling edge, so they are never undefined.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_W   = 2 * REG_W;
  localparam int PSC_LSB = 8;

  typedef enum logic [2:0] {
    SEL_CNT_LO = 3'd0,
    SEL_CNT_HI = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_STAT   = 3'd3,
    SEL_CMP_LO = 3'd4,
    SEL_CMP_HI = 3'd5,
    SEL_INC    = 3'd6,
    SEL_NONE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    cntLoWr;
    logic    cntHiWr;
    logic    ctrlWr;
    logic    statClr;
    logic    cmpLoWr;
    logic    cmpHiWr;
    logic    incWr;
    logic    rdEn;
    regSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/sct_regdec.sv
module sct_regdec
  import sct_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int WIN_W     = 3,
  parameter int CORE_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [WIN_W-1:0]  regWin,
  input  logic [4:0]        regOff,
  input  logic [CORE_W-1:0] regCore,
  output regStrobe_t        stb,
  output logic [CORE_W-1:0] bankSel
);
  logic    bankOk;
  logic    wrOk;
  regSel_e sel;

  always_comb begin
    if (regWin == '0) begin
      bankSel = regCore;
      bankOk  = int'(regCore) < NUM_CORES;
    end else begin
      bankSel = CORE_W'(regWin - WIN_W'(1));
      bankOk  = int'(regWin) <= NUM_CORES;
    end
  end

  always_comb begin
    if (regOff[1:0] == 2'b00) sel = regSel_e'(regOff[4:2]);
    else                      sel = SEL_NONE;
  end

  assign wrOk = regWr && bankOk;

  always_comb begin
    stb.cntLoWr = wrOk && (sel == SEL_CNT_LO);
    stb.cntHiWr = wrOk && (sel == SEL_CNT_HI);
    stb.ctrlWr  = wrOk && (sel == SEL_CTRL);
    stb.statClr = wrOk && (sel == SEL_STAT);
    stb.cmpLoWr = wrOk && (sel == SEL_CMP_LO);
    stb.cmpHiWr = wrOk && (sel == SEL_CMP_HI);
    stb.incWr   = wrOk && (sel == SEL_INC);
    stb.rdEn    = regRd;
    stb.rdSel   = bankOk ? sel : SEL_NONE;
  end

  // R10
  misalign_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regOff[1:0] != 2'b00) |-> (stb.rdSel == SEL_NONE && !stb.ctrlWr &&
                               !stb.cmpLoWr && !stb.cmpHiWr && !stb.incWr));
endmodule

// File: rtl/sct_bank.sv
module sct_bank
  import sct_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             statClr,
  input  logic             cmpLoWr,
  input  logic             cmpHiWr,
  input  logic             incWr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tmrEn,
  input  logic [CNT_W-1:0] cntNext,
  output logic [2:0]       ctrlBits,
  output logic             stat,
  output logic [CNT_W-1:0] cmp,
  output logic [REG_W-1:0] inc,
  output logic             irq
);
  logic             cmpEn, irqEn, autoEn;
  logic             evt, stepOn;
  logic [CNT_W-1:0] gap, rem, advCmp;

  // remainder of num / den, restoring form, one bit per stage
  function automatic logic [CNT_W-1:0] modRem(input logic [CNT_W-1:0] num,
                                              input logic [REG_W-1:0] den);
    logic [REG_W:0] r;
    r = '0;
    for (int k = CNT_W - 1; k >= 0; k--) begin
      r = {r[REG_W-1:0], num[k]};
      if (r >= {1'b0, den}) r = r - {1'b0, den};
    end
    return {{(CNT_W-REG_W){1'b0}}, r[REG_W-1:0]};
  endfunction

  assign evt    = tmrEn && cmpEn && (cntNext >= cmp);
  assign stepOn = evt && autoEn && (inc != '0);
  assign gap    = cntNext - cmp;
  assign rem    = modRem(gap, inc);
  assign advCmp = cntNext - rem + {{(CNT_W-REG_W){1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpEn  <= 1'b0;
      irqEn  <= 1'b0;
      autoEn <= 1'b0;
      stat   <= 1'b0;
      cmp    <= '0;
      inc    <= '0;
    end else begin
      if (ctrlWr) begin
        cmpEn  <= wdata[1];
        irqEn  <= wdata[2];
        autoEn <= wdata[3];
      end
      if (evt)                      stat <= 1'b1;
      else if (statClr && wdata[0]) stat <= 1'b0;
      if (cmpLoWr)      cmp[REG_W-1:0]     <= wdata;
      else if (cmpHiWr) cmp[CNT_W-1:REG_W] <= wdata;
      else if (stepOn)  cmp                <= advCmp;
      if (incWr) inc <= wdata;
    end
  end

  assign ctrlBits = {autoEn, irqEn, cmpEn};
  assign irq      = stat && irqEn;

  // R5
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt |=> stat);

  // R6
  step_passes_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOn && !cmpLoWr && !cmpHiWr) |=> (cmp > $past(cntNext)));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stat && !(statClr && wdata[0])) |=> stat);
endmodule

// File: rtl/sct_datapath.sv
module sct_datapath
  import sct_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int PSC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           stb,
  input  logic [CORE_W-1:0]    bankSel,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  output logic [NUM_CORES-1:0] irq
);
  logic             tmrEn;
  logic [PSC_W-1:0] pscVal, pscCnt;
  logic             tick;
  logic [CNT_W-1:0] cnt, cntNext;

  logic [2:0]       bankCtrl [NUM_CORES];
  logic             bankStat [NUM_CORES];
  logic [CNT_W-1:0] bankCmp  [NUM_CORES];
  logic [REG_W-1:0] bankInc  [NUM_CORES];

  logic [2:0]       selCtrl;
  logic             selStat;
  logic [CNT_W-1:0] selCmp;
  logic [REG_W-1:0] selInc;
  logic [REG_W-1:0] ctrlView, rdValue;

  // shared counter and prescaler
  assign tick    = tmrEn && (pscCnt == pscVal);
  assign cntNext = cnt + {{(CNT_W-1){1'b0}}, tick};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrEn  <= 1'b0;
      pscVal <= '0;
      pscCnt <= '0;
      cnt    <= '0;
    end else begin
      if (!tmrEn || tick) pscCnt <= '0;
      else                pscCnt <= pscCnt + PSC_W'(1);
      if (tmrEn)            cnt                <= cntNext;
      else if (stb.cntLoWr) cnt[REG_W-1:0]     <= wdata;
      else if (stb.cntHiWr) cnt[CNT_W-1:REG_W] <= wdata;
      if (stb.ctrlWr) begin
        tmrEn  <= wdata[0];
        pscVal <= wdata[PSC_LSB +: PSC_W];
      end
    end
  end

  // per-core banks
  for (genvar g = 0; g < NUM_CORES; g++) begin : gBank
    logic hit;
    assign hit = (bankSel == CORE_W'(g));
    sct_bank u_bank (
      .clk      (clk),
      .rstN     (rstN),
      .ctrlWr   (hit && stb.ctrlWr),
      .statClr  (hit && stb.statClr),
      .cmpLoWr  (hit && stb.cmpLoWr),
      .cmpHiWr  (hit && stb.cmpHiWr),
      .incWr    (hit && stb.incWr),
      .wdata    (wdata),
      .tmrEn    (tmrEn),
      .cntNext  (cntNext),
      .ctrlBits (bankCtrl[g]),
      .stat     (bankStat[g]),
      .cmp      (bankCmp[g]),
      .inc      (bankInc[g]),
      .irq      (irq[g])
    );
  end

  // read path
  always_comb begin
    selCtrl = '0;
    selStat = 1'b0;
    selCmp  = '0;
    selInc  = '0;
    for (int g = 0; g < NUM_CORES; g++) begin
      if (bankSel == CORE_W'(g)) begin
        selCtrl = bankCtrl[g];
        selStat = bankStat[g];
        selCmp  = bankCmp[g];
        selInc  = bankInc[g];
      end
    end
  end

  always_comb begin
    ctrlView                     = '0;
    ctrlView[0]                  = tmrEn;
    ctrlView[3:1]                = selCtrl;
    ctrlView[PSC_LSB +: PSC_W]   = pscVal;
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_CNT_LO: rdValue = cnt[REG_W-1:0];
      SEL_CNT_HI: rdValue = cnt[CNT_W-1:REG_W];
      SEL_CTRL:   rdValue = ctrlView;
      SEL_STAT:   rdValue = {{(REG_W-1){1'b0}}, selStat};
      SEL_CMP_LO: rdValue = selCmp[REG_W-1:0];
      SEL_CMP_HI: rdValue = selCmp[CNT_W-1:REG_W];
      SEL_INC:    rdValue = selInc;
      default:    rdValue = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdata <= '0;
    else if (stb.rdEn) rdata <= rdValue;
  end

  // R2
  cnt_single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmrEn |=> (cnt == $past(cnt) + 1 || cnt == $past(cnt)));

  // R2
  cnt_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrEn && !stb.cntLoWr && !stb.cntHiWr) |=> $stable(cnt));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(rdata));
endmodule

// File: rtl/mc_global_timer.sv
module mc_global_timer
  import sct_pkg::*;
#(
  parameter  int NUM_CORES = 4,
  parameter  int PSC_W     = 8,
  localparam int WIN_W     = $clog2(NUM_CORES + 1),
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [WIN_W-1:0]     regWin,
  input  logic [4:0]           regOff,
  input  logic [CORE_W-1:0]    regCore,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  output logic [NUM_CORES-1:0] irqOut
);
  regStrobe_t        stb;
  logic [CORE_W-1:0] bankSel;

  sct_regdec #(
    .NUM_CORES (NUM_CORES),
    .WIN_W     (WIN_W),
    .CORE_W    (CORE_W)
  ) u_regdec (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regRd   (regRd),
    .regWin  (regWin),
    .regOff  (regOff),
    .regCore (regCore),
    .stb     (stb),
    .bankSel (bankSel)
  );

  sct_datapath #(
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W),
    .PSC_W     (PSC_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .bankSel (bankSel),
    .wdata   (regWdata),
    .rdata   (regRdata),
    .irq     (irqOut)
  );
endmodule

// File: tb/mc_global_timer_bench.sv
module mc_global_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWr, regRd;
  logic [2:0]  regWin;
  logic [4:0]  regOff;
  logic [1:0]  regCore;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic [NC-1:0] irqOut;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_global_timer u_mc_global_timer (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regWin(regWin),
    .regOff(regOff), .regCore(regCore), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  // reference model built from the requirements
  logic [63:0] mCnt;
  logic [7:0]  mPsc, mPscVal;
  logic        mTmrEn;
  logic        mCmpEn [NC];
  logic        mIrqEn [NC];
  logic        mAutoEn[NC];
  logic        mStat  [NC];
  logic [63:0] mCmp   [NC];
  logic [31:0] mInc   [NC];
  logic [31:0] mRdata;

  function automatic logic [63:0] passCount(input logic [63:0] c, input logic [63:0] n,
                                            input logic [31:0] s);
    return n - ((n - c) % {32'b0, s}) + {32'b0, s};   // R6
  endfunction

  task automatic modelReset();
    mCnt = '0; mPsc = '0; mPscVal = '0; mTmrEn = 1'b0; mRdata = '0;
    for (int i = 0; i < NC; i++) begin
      mCmpEn[i] = 0; mIrqEn[i] = 0; mAutoEn[i] = 0; mStat[i] = 0;
      mCmp[i] = '0; mInc[i] = '0;
    end
  endtask

  task automatic modelStep();
    int b; bit ok; int sel; logic [31:0] rv; logic tick; logic [63:0] nCnt; bit evt;
    b   = (regWin == 0) ? int'(regCore) : int'(regWin) - 1;
    ok  = b < NC;
    sel = (regOff[1:0] == 0) ? int'(regOff[4:2]) : 7;
    rv  = '0;
    if (ok) begin
      case (sel)
        0: rv = mCnt[31:0];
        1: rv = mCnt[63:32];
        2: rv = {16'b0, mPscVal, 4'b0, mAutoEn[b], mIrqEn[b], mCmpEn[b], mTmrEn};
        3: rv = {31'b0, mStat[b]};
        4: rv = mCmp[b][31:0];
        5: rv = mCmp[b][63:32];
        6: rv = mInc[b];
        default: rv = '0;
      endcase
    end
    if (regRd) mRdata = rv;
    tick = mTmrEn && (mPsc == mPscVal);
    nCnt = mCnt + {63'b0, tick};
    for (int i = 0; i < NC; i++) begin
      evt = mTmrEn && mCmpEn[i] && (nCnt >= mCmp[i]);
      if (evt) mStat[i] = 1;
      else if (regWr && ok && sel == 3 && b == i && regWdata[0]) mStat[i] = 0;
      if (evt && mAutoEn[i] && mInc[i] != 0) mCmp[i] = passCount(mCmp[i], nCnt, mInc[i]);
    end
    mPsc = (!mTmrEn || tick) ? 8'd0 : mPsc + 8'd1;
    if (mTmrEn) mCnt = nCnt;
    else if (regWr && ok && sel == 0) mCnt[31:0]  = regWdata;
    else if (regWr && ok && sel == 1) mCnt[63:32] = regWdata;
    if (regWr && ok) begin
      case (sel)
        2: begin
          mTmrEn = regWdata[0]; mPscVal = regWdata[15:8];
          mCmpEn[b] = regWdata[1]; mIrqEn[b] = regWdata[2]; mAutoEn[b] = regWdata[3];
        end
        4: mCmp[b][31:0]  = regWdata;
        5: mCmp[b][63:32] = regWdata;
        6: mInc[b]        = regWdata;
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else       modelStep();
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int win, input int core, input int off);
    int b;
    b = (win == 0) ? core : win - 1;
    if (b >= NC) return "R9";
    if (off[1:0] != 0) return "R10";
    case (off >> 2)
      0, 1: return "R3";
      2: return "R4";
      3: return "R7";
      4, 5: return "R6";
      6: return "R12";
      default: return "R10";
    endcase
  endfunction

  // one bus cycle, driven from the falling edge, checked at the next falling edge
  task automatic cyc(input bit wr, input bit rd, input int win, input int off,
                     input int core, input logic [31:0] d);
    logic [NC-1:0] expIrq;
    regWr = wr; regRd = rd; regWin = 3'(win); regOff = 5'(off);
    regCore = 2'(core); regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWr = 0; regRd = 0;
    for (int i = 0; i < NC; i++) expIrq[i] = mStat[i] && mIrqEn[i];
    check("R8", {60'b0, irqOut}, {60'b0, expIrq});
    check(rd ? tagOf(win, core, off) : "R11", {32'b0, regRdata}, {32'b0, mRdata});
  endtask

  task automatic wrReg(input int win, input int off, input logic [31:0] d);
    cyc(1, 0, win, off, 0, d);
  endtask

  task automatic rdReg(input int win, input int off, output logic [31:0] v);
    cyc(0, 1, win, off, 0, '0);
    v = regRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v, c, m, last;
    void'($urandom(32'd2024));
    rstN = 0; regWr = 0; regRd = 0; regWin = 0; regOff = 0; regCore = 0; regWdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1: everything reads zero after reset
    for (int off = 0; off < 32; off += 4) begin
      rdReg(1, off, v);
      check("R1", {32'b0, v}, 64'd0);
    end
    check("R1", {60'b0, irqOut}, 64'd0);

    // R2: prescale 2, enabled for ten edges -> three counts
    wrReg(1, 8, 32'h0000_0201);
    idle(9);
    wrReg(1, 8, 32'h0);
    rdReg(1, 0, v);
    check("R2", {32'b0, v}, 64'd3);

    // R3: counter write while running is ignored
    wrReg(1, 8, 32'h0000_FF01);
    wrReg(2, 0, 32'h5555);
    rdReg(1, 0, v);
    check("R3", {32'b0, v}, 64'd3);
    wrReg(1, 8, 32'h0);
    wrReg(2, 0, 32'h5555);
    wrReg(2, 4, 32'h1);
    rdReg(1, 0, v); check("R3", {32'b0, v}, 64'h5555);
    rdReg(1, 4, v); check("R3", {32'b0, v}, 64'h1);
    wrReg(1, 4, 32'h0);

    // R4: shared and banked control bits
    wrReg(2, 8, 32'hFFFF_3F0E);
    rdReg(2, 8, v); check("R4", {32'b0, v}, 64'h3F0E);
    rdReg(3, 8, v); check("R4", {32'b0, v}, 64'h3F00);
    wrReg(2, 8, 32'h0);

    // R5 R6 R8: bank 0 matches and steps forward
    wrReg(1, 16, 32'd10);
    wrReg(1, 20, 32'd0);
    wrReg(1, 24, 32'd7);
    wrReg(1, 8, 32'h0000_000F);
    idle(3);
    wrReg(1, 8, 32'h0000_000E);
    rdReg(1, 0, c);
    rdReg(1, 16, m);
    check("R6", {63'b0, m > c}, 64'd1);
    check("R6", {32'b0, (m - 32'd10) % 32'd7}, 64'd0);
    check("R6", {63'b0, (m - c) <= 32'd7}, 64'd1);
    rdReg(1, 12, v); check("R5", {32'b0, v}, 64'd1);
    check("R8", {63'b0, irqOut[0]}, 64'd1);

    // R7: clear through the alias window as core 0
    cyc(1, 0, 0, 12, 0, 32'h1);
    rdReg(1, 12, v); check("R7", {32'b0, v}, 64'd0);
    check("R8", {63'b0, irqOut[0]}, 64'd0);

    // R9: window routing and invalid windows
    wrReg(5, 24, 32'h99);
    rdReg(1, 24, v); check("R9", {32'b0, v}, 64'd7);
    rdReg(5, 24, v); check("R9", {32'b0, v}, 64'd0);
    cyc(1, 0, 0, 24, 2, 32'h33);
    rdReg(3, 24, v); check("R9", {32'b0, v}, 64'h33);

    // R10: unmapped and misaligned offsets
    rdReg(1, 28, v); check("R10", {32'b0, v}, 64'd0);
    wrReg(1, 18, 32'hFFFF);
    rdReg(1, 16, v); check("R10", {32'b0, v}, {32'b0, m});
    last = v;

    // R11: read data holds without a read strobe
    idle(3);
    check("R11", {32'b0, regRdata}, {32'b0, last});

    // constrained random mix, checked against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      int op, win, core, off;
      logic [31:0] d;
      op   = $urandom_range(0, 9);
      win  = $urandom_range(0, 6);
      core = $urandom_range(0, 3);
      d    = $urandom;
      case (op)
        0, 1, 2: begin
          off = 4 * $urandom_range(0, 7);
          if ($urandom_range(0, 9) == 0) off = off + 1;
          cyc(0, 1, win, off, core, '0);
        end
        3: begin
          d[15:8] = 8'($urandom_range(0, 3));
          d[0] = ($urandom_range(0, 3) != 0);
          cyc(1, 0, win, 8, core, d);
        end
        4: cyc(1, 0, win, 16, core, mCnt[31:0] + 32'($urandom_range(0, 40)));
        5: cyc(1, 0, win, 24, core, 32'($urandom_range(0, 7)));
        6: cyc(1, 0, win, 12, core, d);
        7: cyc(1, 0, win, 0, core, 32'($urandom_range(0, 1000)));
        8: cyc(1, 0, win, 20, core, 32'd0);
        default: cyc(0, 0, win, 0, core, '0);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule